// File: doc/BRIEF.md
# MOESI Line Coherence Controller

This block keeps the five-state coherence status of every line in one cache that sits among several peer caches. It takes processor reads, writes and evictions on one side and snooped reads, read-for-ownership and invalidate requests from the peers on the other. For each event it computes the line's next state. It raises a bus request when this cache must fetch, claim or write back a line, and it raises a supply signal when this cache must provide dirty data to a peer.

The Owned state allows a dirty line to be handed to a peer cache without first updating memory. The holder keeps the line dirty and answers later reads from its own copy. Memory is only updated when an Owned or Modified line is evicted.

A processor request and a snoop can arrive in the same cycle. When both target the same line, the snoop acts first and the processor request sees the state the snoop left behind. All decisions are combinational. The state array updates on the next rising clock edge.

Top module: `moesi_ctrl`

## Requirements
- R1: After reset, every line reads back as Invalid on the query port. State codes: Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4.
- R2: A processor read (op 0) to a line in any valid state raises hit, issues no bus request and leaves the state unchanged. Hit is high for any processor op whose line, after any same-cycle snoop, is not Invalid.
- R3: A processor read to an Invalid line issues bus command 0 (read). The line fills as Exclusive when shared_i is low and as Shared when shared_i is high.
- R4: A processor write (op 1) always leaves the line Modified. From Owned or Shared it issues bus command 2 (invalidate). From Invalid it issues bus command 1 (read-exclusive). From Exclusive or Modified it issues no bus request.
- R5: A processor evict (op 2) leaves the line Invalid. From Modified or Owned it issues bus command 3 (write-back). From any other state it issues no bus request.
- R6: A snooped read (snoop op 0) moves Modified to Owned and raises supply. It keeps Owned with supply raised. It moves Exclusive to Shared without supply. Shared and Invalid stay unchanged without supply.
- R7: A snooped read-exclusive (snoop op 1) or invalidate (snoop op 2) leaves the line Invalid. Supply is raised exactly when the prior state was Modified or Owned.
- R8: When a snoop and a processor request hit the same index in one cycle, the snoop outcome is applied first. The processor request is decided on the post-snoop state, and that result is what the line holds afterwards.
- R9: A snoop and a processor request on different indices in the same cycle both update their lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| proc_valid_i | input | 1 | Processor request valid |
| proc_op_i | input | 2 | 0 read, 1 write, 2 evict, 3 no operation |
| proc_idx_i | input | IDX_W | Line index of the processor request |
| shared_i | input | 1 | Peer shared response, used on a read miss |
| snp_valid_i | input | 1 | Snoop valid |
| snp_op_i | input | 2 | 0 read, 1 read-exclusive, 2 invalidate, 3 no operation |
| snp_idx_i | input | IDX_W | Line index of the snoop |
| query_idx_i | input | IDX_W | Line index to observe |
| proc_hit_o | output | 1 | Processor line valid |
| proc_state_o | output | 3 | Line state after the processor request |
| bus_req_o | output | 1 | Bus request valid |
| bus_cmd_o | output | 2 | 0 read, 1 read-exclusive, 2 invalidate, 3 write-back |
| snp_supply_o | output | 1 | This cache supplies the line's data to the peer |
| snp_state_o | output | 3 | Line state after the snoop |
| query_state_o | output | 3 | Current state of the queried line |

## Verification
A snoop and a processor request can reach the same line in the same cycle. The bench provokes this by preparing one line in each of the five states and then issuing every pairing of snoop op and processor op on that index at once. The expected outcome is computed by applying the snoop rules first and the processor rules to the resulting state. The bench then judges the same-cycle outputs and the state read back on the query port afterwards. Distinct-index pairs are run as well, to show that neither update masks the other.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {PR_RD = 2'd0, PR_WR = 2'd1, PR_EV = 2'd2, PR_NOP = 2'd3} proc_op_e;
  typedef enum logic [1:0] {SN_RD = 2'd0, SN_RDX = 2'd1, SN_INV = 2'd2, SN_NOP = 2'd3} snp_op_e;
  typedef enum logic [1:0] {BC_RD = 2'd0, BC_RDX = 2'd1, BC_INV = 2'd2, BC_WB = 2'd3} bus_cmd_e;

  function automatic logic is_dirty(line_st_e s);
    return (s == ST_M) || (s == ST_O);
  endfunction
endpackage

// File: rtl/moesi_snoop_next.sv
module moesi_snoop_next
  import moesi_pkg::*;
(
  input  logic     valid_i,
  input  snp_op_e  op_i,
  input  line_st_e cur_i,
  output line_st_e nxt_o,
  output logic     supply_o
);
  always_comb begin
    nxt_o    = cur_i;
    supply_o = 1'b0;
    if (valid_i) begin
      unique case (op_i)
        SN_RD: begin
          unique case (cur_i)
            ST_M:    begin nxt_o = ST_O; supply_o = 1'b1; end
            ST_O:    supply_o = 1'b1;
            ST_E:    nxt_o = ST_S;
            default: nxt_o = cur_i;
          endcase
        end
        SN_RDX, SN_INV: begin
          supply_o = is_dirty(cur_i);
          nxt_o    = ST_I;
        end
        default: nxt_o = cur_i;
      endcase
    end
  end
endmodule

// File: rtl/moesi_proc_next.sv
module moesi_proc_next
  import moesi_pkg::*;
(
  input  logic     valid_i,
  input  proc_op_e op_i,
  input  line_st_e cur_i,
  input  logic     shared_i,
  output line_st_e nxt_o,
  output logic     hit_o,
  output logic     bus_req_o,
  output bus_cmd_e bus_cmd_o
);
  always_comb begin
    nxt_o     = cur_i;
    hit_o     = valid_i && (cur_i != ST_I);
    bus_req_o = 1'b0;
    bus_cmd_o = BC_RD;
    if (valid_i) begin
      unique case (op_i)
        PR_RD: begin
          if (cur_i == ST_I) begin
            bus_req_o = 1'b1;
            bus_cmd_o = BC_RD;
            nxt_o     = shared_i ? ST_S : ST_E;
          end
        end
        PR_WR: begin
          nxt_o = ST_M;
          unique case (cur_i)
            ST_O, ST_S: begin bus_req_o = 1'b1; bus_cmd_o = BC_INV; end
            ST_I:       begin bus_req_o = 1'b1; bus_cmd_o = BC_RDX; end
            default:    bus_req_o = 1'b0;
          endcase
        end
        PR_EV: begin
          nxt_o = ST_I;
          if (is_dirty(cur_i)) begin
            bus_req_o = 1'b1;
            bus_cmd_o = BC_WB;
          end
        end
        default: nxt_o = cur_i;
      endcase
    end
  end
endmodule

// File: rtl/moesi_line_store.sv
module moesi_line_store
  import moesi_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwe_i,
  input  logic [IDX_W-1:0] pidx_i,
  input  line_st_e         pst_i,
  input  logic             swe_i,
  input  logic [IDX_W-1:0] sidx_i,
  input  line_st_e         sst_i,
  output line_st_e         lines_o [NUM_LINES]
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_st_e st_q;
    // processor port wins: its value already folds in a same-line snoop
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              st_q <= ST_I;
      else if (pwe_i && pidx_i == IDX_W'(g))    st_q <= pst_i;
      else if (swe_i && sidx_i == IDX_W'(g))    st_q <= sst_i;
    end
    assign lines_o[g] = st_q;
  end
endmodule

// File: rtl/moesi_ctrl.sv
module moesi_ctrl
  import moesi_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             proc_valid_i,
  input  logic [1:0]       proc_op_i,
  input  logic [IDX_W-1:0] proc_idx_i,
  input  logic             shared_i,
  input  logic             snp_valid_i,
  input  logic [1:0]       snp_op_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic [IDX_W-1:0] query_idx_i,
  output logic             proc_hit_o,
  output logic [2:0]       proc_state_o,
  output logic             bus_req_o,
  output logic [1:0]       bus_cmd_o,
  output logic             snp_supply_o,
  output logic [2:0]       snp_state_o,
  output logic [2:0]       query_state_o
);
  line_st_e lines [NUM_LINES];
  line_st_e snp_cur, snp_nxt, proc_cur, proc_nxt;
  bus_cmd_e cmd;
  logic     same_line;

  assign snp_cur   = lines[snp_idx_i];
  assign same_line = snp_valid_i && (snp_idx_i == proc_idx_i);
  assign proc_cur  = same_line ? snp_nxt : lines[proc_idx_i];

  moesi_snoop_next u_snp (
    .valid_i  (snp_valid_i),
    .op_i     (snp_op_e'(snp_op_i)),
    .cur_i    (snp_cur),
    .nxt_o    (snp_nxt),
    .supply_o (snp_supply_o)
  );

  moesi_proc_next u_proc (
    .valid_i   (proc_valid_i),
    .op_i      (proc_op_e'(proc_op_i)),
    .cur_i     (proc_cur),
    .shared_i  (shared_i),
    .nxt_o     (proc_nxt),
    .hit_o     (proc_hit_o),
    .bus_req_o (bus_req_o),
    .bus_cmd_o (cmd)
  );

  moesi_line_store #(.NUM_LINES(NUM_LINES)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwe_i   (proc_valid_i),
    .pidx_i  (proc_idx_i),
    .pst_i   (proc_nxt),
    .swe_i   (snp_valid_i),
    .sidx_i  (snp_idx_i),
    .sst_i   (snp_nxt),
    .lines_o (lines)
  );

  assign bus_cmd_o     = cmd;
  assign proc_state_o  = proc_nxt;
  assign snp_state_o   = snp_nxt;
  assign query_state_o = lines[query_idx_i];

  // R6
  snp_rd_m_to_o_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_op_i == 2'd0 && snp_cur == ST_M && !(proc_valid_i && same_line)
    |=> lines[$past(snp_idx_i)] == ST_O);
  // R7
  snp_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && (snp_op_i == 2'd1 || snp_op_i == 2'd2) |-> snp_state_o == 3'd0);
  // R7
  supply_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_supply_o |-> snp_valid_i && is_dirty(snp_cur));
  // R4
  wr_to_m_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proc_valid_i && proc_op_i == 2'd1 |=> lines[$past(proc_idx_i)] == ST_M);
  // R5
  wb_only_evict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_cmd_o == 2'd3 |-> proc_valid_i && proc_op_i == 2'd2 && proc_state_o == 3'd0);
  // R3
  rd_miss_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proc_valid_i && proc_op_i == 2'd0 && !proc_hit_o |-> bus_req_o && bus_cmd_o == 2'd0);
endmodule

// File: tb/sim_moesi_ctrl.sv
module sim_moesi_ctrl;
  localparam int N = 16;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic pv = 0, sh = 0, sv = 0;
  logic [1:0] pop = 0, sop = 0;
  logic [IW-1:0] pidx = 0, sidx = 0, qidx = 0;
  logic hit, breq, sup;
  logic [1:0] bcmd;
  logic [2:0] pst, sst, qst;

  int checks = 0, errors = 0;
  int exp_st [N];
  bit done = 0;

  always #5 clk = ~clk;

  moesi_ctrl #(.NUM_LINES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .proc_valid_i(pv), .proc_op_i(pop), .proc_idx_i(pidx), .shared_i(sh),
    .snp_valid_i(sv), .snp_op_i(sop), .snp_idx_i(sidx), .query_idx_i(qidx),
    .proc_hit_o(hit), .proc_state_o(pst), .bus_req_o(breq), .bus_cmd_o(bcmd),
    .snp_supply_o(sup), .snp_state_o(sst), .query_state_o(qst)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // states: I0 S1 E2 O3 M4
  function automatic void ref_snp(int cur, int op, output int nxt, output int s);
    s = 0; nxt = cur;
    if (op == 0) begin
      if (cur == 4) begin nxt = 3; s = 1; end
      else if (cur == 3) s = 1;
      else if (cur == 2) nxt = 1;
    end else if (op == 1 || op == 2) begin
      s = (cur == 4 || cur == 3) ? 1 : 0;
      nxt = 0;
    end
  endfunction

  function automatic void ref_proc(int cur, int op, int shr,
                                   output int nxt, output int h, output int rq, output int cm);
    h = (cur != 0) ? 1 : 0; rq = 0; cm = 0; nxt = cur;
    case (op)
      0: if (cur == 0) begin rq = 1; cm = 0; nxt = shr ? 1 : 2; end
      1: begin
        nxt = 4;
        if (cur == 3 || cur == 1) begin rq = 1; cm = 2; end
        else if (cur == 0) begin rq = 1; cm = 1; end
      end
      2: begin nxt = 0; if (cur == 4 || cur == 3) begin rq = 1; cm = 3; end end
      default: ;
    endcase
  endfunction

  task automatic check_line(int idx, string tag);
    @(negedge clk);
    qidx = IW'(idx);
    #1;
    chk(tag, "query_state", int'(qst), exp_st[idx]);
  endtask

  task automatic step(bit p_v, int p_op, int p_i, bit shr, bit s_v, int s_op, int s_i, string tag);
    int sn, ss, pc, pn, ph, prq, pcm;
    @(negedge clk);
    pv = p_v; pop = 2'(p_op); pidx = IW'(p_i); sh = shr;
    sv = s_v; sop = 2'(s_op); sidx = IW'(s_i);
    #2;
    sn = exp_st[s_i]; ss = 0;
    if (s_v) begin
      ref_snp(exp_st[s_i], s_op, sn, ss);
      chk(tag, "snp_supply", int'(sup), ss);
      chk(tag, "snp_state", int'(sst), sn);
    end
    if (p_v) begin
      pc = (s_v && s_i == p_i) ? sn : exp_st[p_i];
      ref_proc(pc, p_op, int'(shr), pn, ph, prq, pcm);
      chk(tag, "proc_hit", int'(hit), ph);
      chk(tag, "proc_state", int'(pst), pn);
      chk(tag, "bus_req", int'(breq), prq);
      if (prq != 0) chk(tag, "bus_cmd", int'(bcmd), pcm);
    end
    @(posedge clk);
    if (s_v) exp_st[s_i] = sn;
    if (p_v) exp_st[p_i] = pn;
    #1;
    pv = 0; sv = 0;
  endtask

  // bring a line to a given state through the ports
  task automatic prep(int idx, int st);
    step(1, 2, idx, 0, 0, 0, 0, "R5");
    case (st)
      1: step(1, 0, idx, 1, 0, 0, 0, "R3");
      2: step(1, 0, idx, 0, 0, 0, 0, "R3");
      3: begin step(1, 1, idx, 0, 0, 0, 0, "R4"); step(0, 0, 0, 0, 1, 0, idx, "R6"); end
      4: step(1, 1, idx, 0, 0, 0, 0, "R4");
      default: ;
    endcase
    check_line(idx, "prep");
  endtask

  initial begin
    for (int i = 0; i < N; i++) exp_st[i] = 0;
    #23 rst_n = 1'b1;
    // R1
    for (int i = 0; i < N; i++) check_line(i, "R1");

    // R2 R3 R4 R5: every state x processor op x shared response
    for (int s = 0; s < 5; s++)
      for (int op = 0; op < 3; op++)
        for (int h = 0; h < 2; h++) begin
          string t;
          prep(1, s);
          t = (op == 1) ? "R4" : (op == 2) ? "R5" : (s == 0) ? "R3" : "R2";
          step(1, op, 1, h[0], 0, 0, 0, t);
          check_line(1, t);
        end

    // R6 R7: every state x snoop op
    for (int s = 0; s < 5; s++)
      for (int op = 0; op < 3; op++) begin
        string t;
        t = (op == 0) ? "R6" : "R7";
        prep(2, s);
        step(0, 0, 0, 0, 1, op, 2, t);
        check_line(2, t);
      end

    // R8: same line, snoop and processor in one cycle
    for (int s = 0; s < 5; s++)
      for (int so = 0; so < 3; so++)
        for (int po = 0; po < 3; po++) begin
          prep(3, s);
          step(1, po, 3, 1, 1, so, 3, "R8");
          check_line(3, "R8");
        end

    // R9: different lines in one cycle
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++) begin
        prep(4, a);
        prep(5, b);
        step(1, 1, 4, 0, 1, (a + b) % 3, 5, "R9");
        check_line(4, "R9");
        check_line(5, "R9");
      end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule